// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block holds a small window of instruction bytes between the fetch stage and a byte-wide code memory port. The decoder asks for 1, 2, 3 or 4 bytes at a linear address. When the queue has enough bytes left, it answers in the same cycle and takes the count off its remaining-bytes counter. When the counter has run out, it refills. A refill loads bytes from the requested address up to the last byte of the aligned `QLEN`-byte window that holds that address, so a refill that starts near the end of a window is short.

A request can need more bytes than are left. In that case the block first captures the bytes it has into a holding register. It then refills from the address just past them and places the newly loaded bytes above the held ones. The decoder is expected to keep reading consecutive addresses. After any jump in the address stream, the fetch stage asserts `flush_i`. Bytes sit in slot `address mod QLEN`. `QLEN` must be a power of two and at least 4.

Top module: `instr_prefetch_queue`

## Requirements
- R1: A refill starting at address S issues one memory request for each of the addresses S, S+1, ... up to the last address of the aligned QLEN-byte window holding S. That is QLEN - (S mod QLEN) requests, in increasing order. Each accepted request returns exactly one byte, and responses come back in request order.
- R2: A refill starts whenever the remaining count is zero or less when a read is presented. Once the refill's last byte arrives, the remaining count equals the number of bytes that refill loaded, and all of the refill's requests have been issued before the read is accepted.
- R3: `rd_size_i` codes 0, 1, 2 and 3 request 1, 2, 3 and 4 bytes. An accepted read lowers the remaining count by that many bytes. Consecutive reads served from bytes already held cause no memory request.
- R4: Read data is little-endian. The byte at the read address goes in bits 7:0 and each higher address goes one lane up. Lanes above the requested size read as zero.
- R5: When some bytes remain but fewer than a read needs, the remaining bytes fill the lowest lanes. A refill then starts at the address just past them, and its bytes fill the upper lanes of the same read.
- R6: `rd_ready_o` stays low while a refill has requests or responses outstanding.
- R7: `flush_i` sets the remaining count to zero and drops any partly assembled read, so the next read refills from its own address. A flush during a refill stops further requests, and responses already owed are taken in and discarded. No read is accepted in a flush cycle.
- R8: While reset is asserted and right after it, no memory request is made and `rd_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drop queued bytes and any refill in flight |
| rd_valid_i | input | 1 | Decoder read request |
| rd_addr_i | input | AW | Linear address of the read's lowest byte |
| rd_size_i | input | 2 | Byte count minus one |
| rd_ready_o | output | 1 | Read accepted this cycle; data valid |
| rd_data_o | output | 32 | Little-endian read data |
| mem_req_o | output | 1 | Memory byte request |
| mem_addr_o | output | AW | Memory byte address |
| mem_gnt_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Memory returns a byte |
| mem_rdata_i | input | 8 | Returned byte |

## Verification
`rd_ready_o` and `rd_data_o` are combinational and are due in the same cycle as the read request whenever enough bytes remain. An empty queue or a short one raises `mem_req_o` one cycle after the read is presented. Requests then advance one address per grant, and the read is answered two cycles after the last byte returns. The bench drives every input at the falling edge and samples outputs 1 ns later. It treats a read as accepted only when `rd_ready_o` is seen high in that sampling slot, and it logs memory handshakes in the same slot. Its expected refill addresses and read data come from a behavioural model of the remaining count and the memory contents, so no check relies on a fixed latency.

// File: rtl/ipq_pkg.sv
package ipq_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE   = 2'd0,
    SZ_WORD   = 2'd1,
    SZ_TRIPLE = 2'd2,
    SZ_DWORD  = 2'd3
  } rd_size_e;

  // byte-lane mask covering the lowest cnt lanes of a 32-bit word
  function automatic logic [31:0] lane_mask(input logic [2:0] cnt);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(cnt)) m[i*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction

endpackage

// File: rtl/ipq_byte_store.sv
module ipq_byte_store #(
  parameter int QLEN = 16,
  parameter int OFFW = $clog2(QLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [OFFW-1:0] wr_slot_i,
  input  logic [7:0]      wr_byte_i,
  input  logic [OFFW-1:0] rd_slot_i,
  output logic [31:0]     rd_bytes_o
);

  logic [7:0] mem_q [QLEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < QLEN; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_slot_i] <= wr_byte_i;
    end
  end

  // four consecutive slots, wrapping inside the window
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [OFFW-1:0] slot;
    assign slot = rd_slot_i + OFFW'(l);
    assign rd_bytes_o[l*8 +: 8] = mem_q[slot];
  end

endmodule

// File: rtl/ipq_refill_seq.sv
module ipq_refill_seq #(
  parameter int AW   = 32,
  parameter int QLEN = 16,
  parameter int OFFW = $clog2(QLEN),
  parameter int CW   = OFFW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   start_addr_i,
  input  logic            abort_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [CW-1:0]   done_len_o,
  output logic            wr_en_o,
  output logic [OFFW-1:0] wr_slot_o,
  output logic [7:0]      wr_byte_o,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_gnt_i,
  input  logic            mem_rvalid_i,
  input  logic [7:0]      mem_rdata_i
);

  logic          busy_q, aborted_q;
  logic [AW-1:0] base_q;
  logic [CW-1:0] len_q, issued_q, recvd_q;
  logic          grant, take_rsp, finishing;

  assign mem_req_o  = busy_q && (issued_q < len_q);
  assign mem_addr_o = base_q + AW'(issued_q);
  assign grant      = mem_req_o && mem_gnt_i;
  assign take_rsp   = busy_q && mem_rvalid_i && (recvd_q < issued_q);
  assign finishing  = busy_q && (issued_q == len_q) && (recvd_q == len_q);

  assign busy_o     = busy_q;
  assign done_o     = finishing && !aborted_q;
  assign done_len_o = len_q;
  assign wr_en_o    = take_rsp && !aborted_q;
  assign wr_slot_o  = base_q[OFFW-1:0] + recvd_q[OFFW-1:0];
  assign wr_byte_o  = mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      aborted_q <= 1'b0;
      base_q    <= '0;
      len_q     <= '0;
      issued_q  <= '0;
      recvd_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q    <= 1'b1;
        aborted_q <= 1'b0;
        base_q    <= start_addr_i;
        len_q     <= CW'(QLEN) - CW'(start_addr_i[OFFW-1:0]);
        issued_q  <= '0;
        recvd_q   <= '0;
      end
    end else if (finishing) begin
      busy_q <= 1'b0;
    end else begin
      if (grant)    issued_q <= issued_q + 1'b1;
      if (take_rsp) recvd_q  <= recvd_q + 1'b1;
      if (abort_i) begin
        // stop issuing; drain what is already owed
        aborted_q <= 1'b1;
        len_q     <= issued_q + CW'(grant);
      end
    end
  end

  // R1
  issue_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (issued_q <= len_q));

  // R6
  recv_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (recvd_q <= issued_q));

  // R1
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant && !abort_i) |=> (!mem_req_o || (mem_addr_o == $past(mem_addr_o) + AW'(1))));

endmodule

// File: rtl/ipq_lane_merge.sv
module ipq_lane_merge
  import ipq_pkg::*;
(
  input  logic [31:0] hold_data_i,
  input  logic [2:0]  hold_cnt_i,
  input  logic [31:0] win_bytes_i,
  input  logic [2:0]  take_cnt_i,
  output logic [31:0] merged_o
);

  logic [31:0] fresh;

  assign fresh    = win_bytes_i & lane_mask(take_cnt_i);
  assign merged_o = hold_data_i | (fresh << {hold_cnt_i, 3'b000});

endmodule

// File: rtl/instr_prefetch_queue.sv
module instr_prefetch_queue
  import ipq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int QLEN = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [1:0]    rd_size_i,
  output logic          rd_ready_o,
  output logic [31:0]   rd_data_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [7:0]    mem_rdata_i
);

  localparam int OFFW = $clog2(QLEN);
  localparam int CW   = OFFW + 1;
  localparam int RW   = OFFW + 2;

  logic signed [RW-1:0] remain_q;
  logic [2:0]           hold_cnt_q;
  logic [31:0]          hold_data_q;

  rd_size_e             sz;
  logic [2:0]           n_bytes, need, take_cnt;
  logic signed [RW-1:0] need_s;
  logic [AW-1:0]        eff_addr, fill_addr;
  logic                 can_go, rem_pos, enough, serve, partial, start_fill;
  logic [31:0]          win_bytes, merged;

  logic                 fill_busy, fill_done, wr_en;
  logic [CW-1:0]        fill_len;
  logic [OFFW-1:0]      wr_slot;
  logic [7:0]           wr_byte;

  assign sz       = rd_size_e'(rd_size_i);
  assign n_bytes  = {1'b0, sz} + 3'd1;
  assign need     = n_bytes - hold_cnt_q;
  assign need_s   = $signed(RW'(need));
  assign eff_addr = rd_addr_i + AW'(hold_cnt_q);

  assign can_go     = rd_valid_i && !fill_busy && !flush_i;
  assign rem_pos    = remain_q > 0;
  assign enough     = remain_q >= need_s;
  assign serve      = can_go && enough;
  assign partial    = can_go && rem_pos && !enough;
  assign start_fill = can_go && !enough;
  assign take_cnt   = enough ? need : remain_q[2:0];
  assign fill_addr  = eff_addr + (partial ? AW'(take_cnt) : AW'(0));

  assign rd_ready_o = serve;
  assign rd_data_o  = merged;

  ipq_byte_store #(.QLEN(QLEN), .OFFW(OFFW)) store_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_slot_i  (wr_slot),
    .wr_byte_i  (wr_byte),
    .rd_slot_i  (eff_addr[OFFW-1:0]),
    .rd_bytes_o (win_bytes)
  );

  ipq_refill_seq #(.AW(AW), .QLEN(QLEN), .OFFW(OFFW), .CW(CW)) refill_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_fill),
    .start_addr_i (fill_addr),
    .abort_i      (flush_i),
    .busy_o       (fill_busy),
    .done_o       (fill_done),
    .done_len_o   (fill_len),
    .wr_en_o      (wr_en),
    .wr_slot_o    (wr_slot),
    .wr_byte_o    (wr_byte),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i)
  );

  ipq_lane_merge merge_i (
    .hold_data_i (hold_data_q),
    .hold_cnt_i  (hold_cnt_q),
    .win_bytes_i (win_bytes),
    .take_cnt_i  (take_cnt),
    .merged_o    (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q    <= '0;
      hold_cnt_q  <= '0;
      hold_data_q <= '0;
    end else if (flush_i) begin
      remain_q    <= '0;
      hold_cnt_q  <= '0;
      hold_data_q <= '0;
    end else if (fill_done) begin
      remain_q <= $signed(RW'(fill_len));
    end else if (serve) begin
      remain_q    <= remain_q - need_s;
      hold_cnt_q  <= '0;
      hold_data_q <= '0;
    end else if (partial) begin
      // low lanes captured; refill supplies the rest
      remain_q    <= '0;
      hold_cnt_q  <= hold_cnt_q + take_cnt;
      hold_data_q <= merged;
    end
  end

  // R6
  ready_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ready_o |-> !fill_busy);

  // R2
  remain_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_q >= 0) && (remain_q <= QLEN));

  // R2
  refill_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_done && !flush_i) |=> (remain_q == $signed(RW'($past(fill_len)))));

  // R7
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ((remain_q == 0) && (hold_cnt_q == 3'd0)));

  // R3
  consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_ready_o) |=> (remain_q == $past(remain_q) - $past(need_s)));

  // R5
  split_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    partial |=> fill_busy);

endmodule

// File: tb/instr_prefetch_queue_tb_top.sv
`timescale 1ns/1ps
module instr_prefetch_queue_tb_top;

  localparam int AW   = 32;
  localparam int QLEN = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush_i, rd_valid_i, rd_ready_o, mem_req_o, mem_gnt_i, mem_rvalid_i;
  logic [AW-1:0] rd_addr_i, mem_addr_o;
  logic [1:0]    rd_size_i;
  logic [31:0]   rd_data_o;
  logic [7:0]    mem_rdata_i;

  always #4 clk = ~clk;

  instr_prefetch_queue #(.AW(AW), .QLEN(QLEN)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .flush_i      (flush_i),
    .rd_valid_i   (rd_valid_i),
    .rd_addr_i    (rd_addr_i),
    .rd_size_i    (rd_size_i),
    .rd_ready_o   (rd_ready_o),
    .rd_data_o    (rd_data_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i)
  );

  int          checks = 0;
  int          fails  = 0;
  int unsigned tick_no = 0;
  bit          finished = 0;

  logic [AW-1:0] exp_q[$];
  logic [7:0]    pend_d[$];
  int unsigned   pend_t[$];
  int            m_rem = 0;
  logic [15:0]   lfsr = 16'hACE1;

  logic          drv_valid = 0, drv_flush = 0;
  logic [AW-1:0] drv_addr = '0;
  logic [1:0]    drv_size = '0;
  bit            rv_now, accepted, flushed, is_split;
  logic [31:0]   got_data, exp_data;
  int            hs_cnt = 0;

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    return 8'(a * 37 + (a >> 8) * 11 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  // one cycle: drive at falling edge, observe 1 ns later
  task automatic tick();
    @(negedge clk);
    rd_valid_i   = drv_valid;
    rd_addr_i    = drv_addr;
    rd_size_i    = drv_size;
    flush_i      = drv_flush;
    mem_gnt_i    = lfsr[0] | lfsr[3];
    rv_now       = 0;
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = 8'h00;
    if (pend_d.size() > 0 && pend_t[0] < tick_no && (lfsr[1] | lfsr[2])) begin
      rv_now       = 1;
      mem_rvalid_i = 1'b1;
      mem_rdata_i  = pend_d.pop_front();
      void'(pend_t.pop_front());
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1;
    accepted = 0;
    if (mem_req_o && mem_gnt_i) begin
      hs_cnt++;
      if (exp_q.size() == 0) begin
        // R3: no fetch while enough bytes remain
        chk(0, "R3", "unexpected fetch", mem_addr_o, 32'h0);
      end else begin
        logic [AW-1:0] e;
        e = exp_q.pop_front();
        chk(mem_addr_o == e, "R1", "fetch address", mem_addr_o, e);
      end
      pend_d.push_back(mb(mem_addr_o));
      pend_t.push_back(tick_no);
    end
    if (exp_q.size() > 0 || pend_d.size() > 0 || rv_now)
      chk(!rd_ready_o, "R6", "ready during refill", {31'd0, rd_ready_o}, 32'd0);
    if (drv_valid && rd_ready_o) begin
      accepted = 1;
      got_data = rd_data_o;
    end
    if (drv_flush) begin
      m_rem = 0;
      exp_q.delete();
      flushed = 1;
    end
    tick_no++;
  endtask

  task automatic plan(input logic [AW-1:0] a, input int sz);
    int n, taken;
    n = sz + 1;
    taken = 0;
    is_split = 0;
    exp_data = '0;
    for (int i = 0; i < n; i++) exp_data |= 32'(mb(a + AW'(i))) << (8 * i);
    while (taken < n) begin
      if (m_rem <= 0) begin
        logic [AW-1:0] s;
        int len;
        s = a + AW'(taken);
        len = QLEN - int'(s % AW'(QLEN));
        for (int k = 0; k < len; k++) exp_q.push_back(s + AW'(k));
        m_rem = len;
        if (taken > 0) is_split = 1;
      end
      begin
        int t;
        t = (m_rem < n - taken) ? m_rem : n - taken;
        m_rem -= t;
        taken += t;
      end
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int sz, input int flush_at);
    plan(a, sz);
    drv_valid = 1;
    drv_addr  = a;
    drv_size  = 2'(sz);
    flushed   = 0;
    for (int i = 0; i < 400; i++) begin
      drv_flush = (i == flush_at);
      tick();
      if (flushed) begin
        flushed = 0;
        m_rem = 0;
        plan(a, sz);
      end
      if (accepted) break;
    end
    drv_valid = 0;
    drv_flush = 0;
    if (!accepted) begin
      chk(0, "R6", "read never accepted", a, 32'h0);
    end else begin
      chk(got_data == exp_data, is_split ? "R5" : "R4", "read data", got_data, exp_data);
      chk(exp_q.size() == 0, "R2", "refill incomplete at accept", exp_q.size(), 32'd0);
    end
  endtask

  task automatic do_flush();
    drv_flush = 1;
    tick();
    drv_flush = 0;
    flushed = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL R6 watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    rst_n = 1'b0;
    // R8: reset holds off requests and ready even with a read pending
    drv_valid = 1;
    drv_addr  = 32'h100;
    drv_size  = 2'd3;
    tick();
    chk(!rd_ready_o && !mem_req_o, "R8", "ready/req in reset",
        {30'd0, rd_ready_o, mem_req_o}, 32'd0);
    drv_valid = 0;
    tick();
    rst_n = 1'b1;
    tick();
    chk(!rd_ready_o && !mem_req_o, "R8", "ready/req after reset",
        {30'd0, rd_ready_o, mem_req_o}, 32'd0);

    // sequential stream with mixed sizes: R1-style refills, R3 consumption, R4/R5 data
    a = 32'h1003;
    for (int i = 0; i < 60; i++) begin
      int sz;
      sz = (i * 3 + i / 5) % 4;
      do_read(a, sz, -1);
      a += AW'(sz + 1);
      if (i % 7 == 0) idle(2);
    end

    // R5: short first refill (one byte) then split dword
    do_flush();
    do_read(32'h20F, 3, -1);
    do_read(32'h213, 1, -1);

    // R5: two-byte first refill for a three-byte read
    do_flush();
    do_read(32'h40E, 2, -1);
    a = 32'h411;
    for (int i = 0; i < 8; i++) begin
      do_read(a, 3, -1);
      a += 4;
    end

    // R7: flush with bytes remaining forces a refill at the next address
    do_flush();
    do_read(32'h500, 0, -1);
    idle(2);
    do_flush();
    hs_cnt = 0;
    do_read(32'h501, 1, -1);
    chk(hs_cnt == QLEN - 1, "R7", "refill length after flush", hs_cnt, QLEN - 1);

    // R7: flush in the middle of a refill, then continue sequentially
    do_flush();
    do_read(32'h600, 3, 3);
    a = 32'h604;
    for (int i = 0; i < 10; i++) begin
      do_read(a, i % 4, -1);
      a += AW'(i % 4 + 1);
    end

    idle(30);
    chk(exp_q.size() == 0 && pend_d.size() == 0, "R1", "requests or responses left over",
        exp_q.size() + pend_d.size(), 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule